// File: doc/BRIEF.md
# Display Controller Register Block

This block is the software-visible register file of a color panel controller. It sits on a simple 32-bit bus with separate read and write strobes and a byte address, and holds the four panel timing words, the upper and lower frame base addresses, the control word, the interrupt mask and a sticky raw interrupt status. It decodes the panel width and height from packed fields of the first two timing words and brings the control word out as decoded fields, among them an active flag that is set only when enable and power are both on.

A two-bit version strap picks the register layout and identification values. With the strap at 0 the mask sits below the control word. With any other value the two are swapped for both reads and writes. Strap values 2 and 3 also change two of the eight read-only identification bytes. A 128-word window of the map is passed through to an external palette store over a small port with a one-cycle read latency. Each read returns its data one cycle after the strobe. Any access to an unmapped location is flagged with a one-cycle error pulse. Each accepted write produces a one-cycle change pulse, so a display engine knows when to refetch its settings.

Top module: `lcdc_regif`

## Requirements
- R1: Word offsets 0 to 3 (byte 0x00 to 0x0C) hold timing words 0 to 3, offset 4 (0x10) the upper base and offset 5 (0x14) the lower base. All six read back exactly as written and are zero after reset. The upper and lower bases also appear on the `upper_base` and `lower_base` outputs.
- R2: With `ver_sel` = 0, byte 0x18 is the interrupt mask and 0x1C the control word. With any other `ver_sel` value the two addresses are exchanged, for both read and write. The mask keeps its low NIRQ bits and reads back zero-extended.
- R3: A high `int_evt` bit sets the matching raw status bit on the next clock, and the bit stays set. Byte 0x20 reads the raw status. Byte 0x24 reads the status ANDed with the mask. `irq` is high when any bit of status AND mask is set.
- R4: A write to byte 0x28 clears every status bit whose data bit is 1. If an event arrives for a bit in the same cycle as its clear, the bit stays set.
- R5: Bytes 0x2C and 0x30 read the current upper and lower base, which equal the programmed bases.
- R6: `panel_width` = ((timing0 & 0xFC) + 4) * 4 and `panel_height` = (timing1 & 0x3FF) + 1, both following the timing write on the next cycle. After reset they are 16 and 1.
- R7: Control word bit 0 is enable, bits 3:1 are `bpp_code`, bit 8 is `bgr_order`, bit 9 is `be_bytes`, bit 10 is `be_pixels` and bit 11 is power. `active` is high only when bits 0 and 11 are both set.
- R8: Byte addresses 0xFE0 + 4k (k = 0 to 7) read one identification byte each, zero-extended. For `ver_sel` 0 or 1 the bytes are 0x10,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1. For `ver_sel` 2 or 3 the bytes for k=0 and k=2 are 0x11 and 0x24, and the rest are unchanged.
- R9: Byte addresses 0x200 to 0x3FC form the palette window. An access there drives `pal_idx` = (addr − 0x200) >> 2 together with `pal_wr` and `pal_wdata`, or with `pal_rd`. A read returns `pal_rdata` in the response cycle.
- R10: An access to any other address returns 0 on a read and changes nothing on a write. The read-only offsets 0x20, 0x24, 0x2C, 0x30 and the identification bytes count as unmapped for writes, and 0x28 counts as unmapped for reads. `err_pulse` is high for one cycle, in the cycle after such an access.
- R11: `cfg_changed` is high for one cycle, in the cycle after each accepted write, including palette writes and status clears. It stays low after an unmapped write.
- R12: `rsp_valid` is high in exactly the cycle after each `bus_rd` strobe, and `rsp_rdata` holds that read's data during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ver_sel | input | 2 | Version strap: layout and identification select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after bus_rd |
| rsp_rdata | output | DATA_W | Read data |
| err_pulse | output | 1 | Unmapped access flag |
| cfg_changed | output | 1 | Accepted write flag |
| int_evt | input | NIRQ | Interrupt event inputs |
| irq | output | 1 | Masked interrupt request |
| pal_rd | output | 1 | Palette read strobe |
| pal_wr | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | DATA_W | Palette write data |
| pal_rdata | input | DATA_W | Palette read data, one cycle after pal_rd |
| upper_base | output | DATA_W | Upper frame base |
| lower_base | output | DATA_W | Lower frame base |
| panel_width | output | 11 | Panel width in pixels |
| panel_height | output | 11 | Panel height in lines |
| active | output | 1 | Enable and power both set |
| bpp_code | output | 3 | Bits-per-pixel code |
| bgr_order | output | 1 | Blue/red swap |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order within a byte |

## Verification
The hardest case to reach from the ports is a status clear that meets a new event on the same bit in the same clock. In that case the set must win and a neighbouring bit must still clear. The stimulus gets there by driving the event inputs inside the same write task that issues the clear, so both land on one edge. The result is then read back through the raw-status address. The strap-dependent swap is also hard to cover from outside, because one bus address reaches two different registers. The stimulus changes the strap partway through the run and writes through one alias. It then reads through the other alias and checks the decoded control outputs, so a swap in only one direction is caught.

// File: rtl/lcdc_pkg.sv
// Shared constants, select type and identification values for the
// display controller register block. Assumes a 4 KiB byte-addressed map.
package lcdc_pkg;

    // Word offsets of the low register bank.
    localparam int unsigned WO_UBASE = 4;
    localparam int unsigned WO_LBASE = 5;
    localparam int unsigned WO_SLOT6 = 6;
    localparam int unsigned WO_SLOT7 = 7;
    localparam int unsigned WO_RAW   = 8;
    localparam int unsigned WO_MSTAT = 9;
    localparam int unsigned WO_CLR   = 10;
    localparam int unsigned WO_UCUR  = 11;
    localparam int unsigned WO_LCUR  = 12;
    localparam int unsigned N_TIMING = 4;

    // Control word bit positions.
    localparam int unsigned CB_EN  = 0;
    localparam int unsigned CB_BPP = 1;
    localparam int unsigned CB_BGR = 8;
    localparam int unsigned CB_BEB = 9;
    localparam int unsigned CB_BEP = 10;
    localparam int unsigned CB_PWR = 11;

    // Decoded location of one bus access.
    typedef struct packed {
        logic [N_TIMING-1:0] tim;
        logic ubase;
        logic lbase;
        logic ctrl;
        logic mask;
        logic raw;
        logic mstat;
        logic clr;
        logic ucur;
        logic lcur;
        logic pal;
        logic id;
    } lcdc_sel_t;

    // Identification byte k; newer selects the later variant's values.
    function automatic logic [7:0] lcdc_id_byte(input logic newer, input logic [2:0] k);
        logic [7:0] b;
        case (k)
            3'd0:    b = newer ? 8'h11 : 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = newer ? 8'h24 : 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
// Address decoder: maps a byte address to one register select.
// The strap-controlled swap of the mask and control slots happens here.
// It assumes ADDR_W >= 10, so that the palette window and the
// identification block can both be decoded.
module lcdc_addr_dec
    import lcdc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              swap,
    output lcdc_sel_t         sel,
    output logic              rd_ok,
    output logic              wr_ok
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]   word;
    logic [N_TIMING-1:0] tim_hit;

    assign word = addr[ADDR_W-1:2];

    // One compare per timing word.
    for (genvar g = 0; g < N_TIMING; g++) begin : g_tim
        assign tim_hit[g] = (word == WORD_W'(g));
    end

    // Decode the remaining single-word registers and the windows.
    always_comb begin
        sel       = '0;
        sel.tim   = tim_hit;
        sel.ubase = (word == WORD_W'(WO_UBASE));
        sel.lbase = (word == WORD_W'(WO_LBASE));
        sel.mask  = swap ? (word == WORD_W'(WO_SLOT7)) : (word == WORD_W'(WO_SLOT6));
        sel.ctrl  = swap ? (word == WORD_W'(WO_SLOT6)) : (word == WORD_W'(WO_SLOT7));
        sel.raw   = (word == WORD_W'(WO_RAW));
        sel.mstat = (word == WORD_W'(WO_MSTAT));
        sel.clr   = (word == WORD_W'(WO_CLR));
        sel.ucur  = (word == WORD_W'(WO_UCUR));
        sel.lcur  = (word == WORD_W'(WO_LCUR));
        sel.pal   = (word[WORD_W-1:7] == (WORD_W-7)'(1));
        sel.id    = &word[WORD_W-1:3];
    end

    // Which locations may be read and which may be written.
    assign rd_ok = (|sel.tim) | sel.ubase | sel.lbase | sel.ctrl | sel.mask |
                   sel.raw | sel.mstat | sel.ucur | sel.lcur | sel.pal | sel.id;
    assign wr_ok = (|sel.tim) | sel.ubase | sel.lbase | sel.ctrl | sel.mask |
                   sel.clr | sel.pal;

endmodule

// File: rtl/lcdc_geom.sv
// Panel geometry: turns the packed timing fields into a pixel width and a
// line count. Purely combinational, so results follow the stored words.
// It assumes GEOM_W >= 11, which holds the largest result of 1024.
module lcdc_geom #(
    parameter int unsigned GEOM_W = 11
) (
    input  logic [7:0]        t0_low,
    input  logic [9:0]        t1_low,
    output logic [GEOM_W-1:0] width,
    output logic [GEOM_W-1:0] height
);
    logic [6:0]  pairs;
    logic [10:0] lines;

    // Width is 16 pixels per step of the 6-bit field, plus one step.
    assign pairs  = {1'b0, t0_low[7:2]} + 7'd1;
    assign width  = GEOM_W'(pairs) << 4;
    // Height is the 10-bit field plus one.
    assign lines  = {1'b0, t1_low} + 11'd1;
    assign height = GEOM_W'(lines);

endmodule

// File: rtl/lcdc_irq.sv
// Sticky interrupt status with per-bit clear and a masked request.
// When an event and a clear land on the same bit in one cycle, the event wins.
module lcdc_irq #(
    parameter int unsigned NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] evt,
    input  logic            clr_en,
    input  logic [NIRQ-1:0] clr_bits,
    input  logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] raw,
    output logic            irq
);
    for (genvar g = 0; g < NIRQ; g++) begin : g_bit
        // Set on an event, otherwise clear on a matching clear bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                raw[g] <= 1'b0;
            else if (evt[g])
                raw[g] <= 1'b1;
            else if (clr_en && clr_bits[g])
                raw[g] <= 1'b0;
        end
    end

    assign irq = |(raw & mask);

endmodule

// File: rtl/lcdc_regif.sv
// Display controller register block (top). It stores the timing, base,
// control and mask words, decodes geometry and control fields, passes
// palette-window accesses to an external store, and returns read data
// one cycle after each read strobe.
// Assumes: the palette store answers pal_rd with pal_rdata one cycle later.
// A read and a write in the same cycle are both carried out, and the read
// returns the value from before the write.
module lcdc_regif
    import lcdc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NIRQ   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ver_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              err_pulse,
    output logic              cfg_changed,
    input  logic [NIRQ-1:0]   int_evt,
    output logic              irq,
    output logic              pal_rd,
    output logic              pal_wr,
    output logic [6:0]        pal_idx,
    output logic [DATA_W-1:0] pal_wdata,
    input  logic [DATA_W-1:0] pal_rdata,
    output logic [DATA_W-1:0] upper_base,
    output logic [DATA_W-1:0] lower_base,
    output logic [10:0]       panel_width,
    output logic [10:0]       panel_height,
    output logic              active,
    output logic [2:0]        bpp_code,
    output logic              bgr_order,
    output logic              be_bytes,
    output logic              be_pixels
);
    localparam int unsigned PAL_AW = 7;
    localparam int unsigned GEOM_W = 11;

    lcdc_sel_t         sel;
    logic              rd_ok;
    logic              wr_ok;
    logic              wr_go;
    logic              swap;
    logic              newer_id;
    logic [DATA_W-1:0] tim_q [N_TIMING];
    logic [DATA_W-1:0] ubase_q;
    logic [DATA_W-1:0] lbase_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [NIRQ-1:0]   mask_q;
    logic [NIRQ-1:0]   irq_raw;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              pal_q;

    assign swap     = (ver_sel != 2'd0);
    assign newer_id = ver_sel[1];
    assign wr_go    = bus_wr & wr_ok;

    lcdc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (bus_addr),
        .swap  (swap),
        .sel   (sel),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    // Timing words: one register per word.
    for (genvar g = 0; g < N_TIMING; g++) begin : g_timreg
        // Capture the timing word on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tim_q[g] <= '0;
            else if (bus_wr && sel.tim[g])
                tim_q[g] <= bus_wdata;
        end
    end

    // Capture the bases, control word and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ubase_q <= '0;
            lbase_q <= '0;
            ctrl_q  <= '0;
            mask_q  <= '0;
        end else if (bus_wr) begin
            if (sel.ubase) ubase_q <= bus_wdata;
            if (sel.lbase) lbase_q <= bus_wdata;
            if (sel.ctrl)  ctrl_q  <= bus_wdata;
            if (sel.mask)  mask_q  <= bus_wdata[NIRQ-1:0];
        end
    end

    lcdc_irq #(.NIRQ(NIRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (int_evt),
        .clr_en   (bus_wr & sel.clr),
        .clr_bits (bus_wdata[NIRQ-1:0]),
        .mask     (mask_q),
        .raw      (irq_raw),
        .irq      (irq)
    );

    lcdc_geom #(.GEOM_W(GEOM_W)) u_geom (
        .t0_low (tim_q[0][7:0]),
        .t1_low (tim_q[1][9:0]),
        .width  (panel_width),
        .height (panel_height)
    );

    // Select the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < N_TIMING; i++)
            if (sel.tim[i]) rd_mux = tim_q[i];
        if (sel.ubase || sel.ucur) rd_mux = ubase_q;
        if (sel.lbase || sel.lcur) rd_mux = lbase_q;
        if (sel.ctrl)  rd_mux = ctrl_q;
        if (sel.mask)  rd_mux = DATA_W'(mask_q);
        if (sel.raw)   rd_mux = DATA_W'(irq_raw);
        if (sel.mstat) rd_mux = DATA_W'(irq_raw & mask_q);
        if (sel.id)    rd_mux = DATA_W'(lcdc_id_byte(newer_id, bus_addr[4:2]));
    end

    // Register the read response, the error flag and the change flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rdata_q     <= '0;
            pal_q       <= 1'b0;
            err_pulse   <= 1'b0;
            cfg_changed <= 1'b0;
        end else begin
            rsp_valid   <= bus_rd;
            rdata_q     <= bus_rd ? rd_mux : '0;
            pal_q       <= bus_rd & sel.pal;
            err_pulse   <= (bus_rd & ~rd_ok) | (bus_wr & ~wr_ok);
            cfg_changed <= wr_go;
        end
    end

    assign rsp_rdata = pal_q ? pal_rdata : rdata_q;

    // Palette window pass-through.
    assign pal_rd    = bus_rd & sel.pal;
    assign pal_wr    = bus_wr & sel.pal;
    assign pal_idx   = bus_addr[PAL_AW+1:2];
    assign pal_wdata = bus_wdata;

    // Decoded outputs.
    assign upper_base = ubase_q;
    assign lower_base = lbase_q;
    assign active     = ctrl_q[CB_EN] & ctrl_q[CB_PWR];
    assign bpp_code   = ctrl_q[CB_BPP+2:CB_BPP];
    assign bgr_order  = ctrl_q[CB_BGR];
    assign be_bytes   = ctrl_q[CB_BEB];
    assign be_pixels  = ctrl_q[CB_BEP];

endmodule

// File: rtl/lcdc_regif_chk.sv
// Property checker for lcdc_regif, attached through bind.
module lcdc_regif_chk #(
    parameter int unsigned NIRQ = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic            rsp_valid,
    input logic            err_pulse,
    input logic            cfg_changed,
    input logic            pal_rd,
    input logic            pal_wr,
    input logic [10:0]     panel_width,
    input logic [10:0]     panel_height,
    input logic            active,
    input logic [NIRQ-1:0] int_evt,
    input logic [NIRQ-1:0] irq_raw
);
    a_r12_rsp_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(bus_rd));

    a_r10_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(bus_rd || bus_wr));

    a_r11_change_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_changed |-> $past(bus_wr));

    a_r6_geom_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> ($stable(panel_width) && $stable(panel_height)));

    a_r7_active_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (active != $past(active)) |-> $past(bus_wr));

    a_r9_palette_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_rd || pal_wr) |=> !err_pulse);

    for (genvar g = 0; g < NIRQ; g++) begin : g_evt
        a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            int_evt[g] |=> irq_raw[g]);
    end

endmodule

bind lcdc_regif lcdc_regif_chk #(.NIRQ(NIRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .rsp_valid    (rsp_valid),
    .err_pulse    (err_pulse),
    .cfg_changed  (cfg_changed),
    .pal_rd       (pal_rd),
    .pal_wr       (pal_wr),
    .panel_width  (panel_width),
    .panel_height (panel_height),
    .active       (active),
    .int_evt      (int_evt),
    .irq_raw      (irq_raw)
);

// File: tb/sim_lcdc_regif.sv
// Scoreboard bench: read tasks queue expected data, and a monitor compares
// it when rsp_valid appears. Inputs change and outputs are sampled on negedges.
module sim_lcdc_regif;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ver_sel = 2'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  int_evt = '0;
    logic [31:0] pal_rdata = '0;
    logic        rsp_valid, err_pulse, cfg_changed, irq, pal_rd, pal_wr;
    logic [31:0] rsp_rdata, pal_wdata, upper_base, lower_base;
    logic [6:0]  pal_idx;
    logic [10:0] panel_width, panel_height;
    logic        active, bgr_order, be_bytes, be_pixels;
    logic [2:0]  bpp_code;

    logic [31:0] pmem [128];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdc_regif u0 (
        .clk(clk), .rst_n(rst_n), .ver_sel(ver_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .err_pulse(err_pulse), .cfg_changed(cfg_changed),
        .int_evt(int_evt), .irq(irq), .pal_rd(pal_rd), .pal_wr(pal_wr), .pal_idx(pal_idx),
        .pal_wdata(pal_wdata), .pal_rdata(pal_rdata), .upper_base(upper_base),
        .lower_base(lower_base), .panel_width(panel_width), .panel_height(panel_height),
        .active(active), .bpp_code(bpp_code), .bgr_order(bgr_order), .be_bytes(be_bytes),
        .be_pixels(be_pixels)
    );

    // External palette store with one-cycle read latency.
    always @(posedge clk) begin
        if (pal_wr) pmem[pal_idx] <= pal_wdata;
        if (pal_rd) pal_rdata <= pmem[pal_idx];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected value when a response appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected response", rsp_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] ev,
                             input bit exp_err, input string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; int_evt = ev;
        @(negedge clk);
        bus_wr = 1'b0; int_evt = '0;
        check(err_pulse === exp_err, {tag, " R10 err_pulse"}, 32'(err_pulse), 32'(exp_err));
        check(cfg_changed === !exp_err, {tag, " R11 cfg_changed"}, 32'(cfg_changed), 32'(!exp_err));
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input bit exp_err,
                            input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
        check(rsp_valid === 1'b1, {tag, " R12 rsp_valid"}, 32'(rsp_valid), 32'h1);
        check(err_pulse === exp_err, {tag, " R10 err_pulse"}, 32'(err_pulse), 32'(exp_err));
    endtask

    function automatic logic [31:0] exp_width(input logic [31:0] t0);
        return ((t0 & 32'hFC) + 32'd4) * 32'd4;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    logic [7:0] id_old [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    initial begin
        for (int i = 0; i < 128; i++) pmem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R6, R7, R3, R12).
        check(panel_width === 11'd16, "R6 reset width", 32'(panel_width), 32'd16);
        check(panel_height === 11'd1, "R6 reset height", 32'(panel_height), 32'd1);
        check(active === 1'b0, "R7 reset active", 32'(active), 32'd0);
        check(irq === 1'b0, "R3 reset irq", 32'(irq), 32'd0);
        check(rsp_valid === 1'b0, "R12 idle rsp_valid", 32'(rsp_valid), 32'd0);
        for (int i = 0; i < 13; i++)
            if (i != 10) bus_read(12'(i * 4), 32'h0, 1'b0, "R1 reset readback");

        // R1: timing words and bases read back.
        bus_write(12'h000, 32'h1234_5604, 4'h0, 1'b0, "R1 t0");
        check(32'(panel_width) === exp_width(32'h1234_5604), "R6 width t0=04", 32'(panel_width), 32'd32);
        bus_write(12'h004, 32'hFFFF_FC10, 4'h0, 1'b0, "R1 t1");
        check(panel_height === 11'd17, "R6 height t1=010", 32'(panel_height), 32'd17);
        bus_write(12'h008, 32'hDEAD_BEEF, 4'h0, 1'b0, "R1 t2");
        bus_write(12'h00C, 32'h0BAD_F00D, 4'h0, 1'b0, "R1 t3");
        bus_write(12'h010, 32'h8000_1000, 4'h0, 1'b0, "R1 ubase");
        bus_write(12'h014, 32'h8004_0000, 4'h0, 1'b0, "R1 lbase");
        check(upper_base === 32'h8000_1000, "R1 upper_base out", upper_base, 32'h8000_1000);
        check(lower_base === 32'h8004_0000, "R1 lower_base out", lower_base, 32'h8004_0000);
        bus_read(12'h000, 32'h1234_5604, 1'b0, "R1 t0 readback");
        bus_read(12'h004, 32'hFFFF_FC10, 1'b0, "R1 t1 readback");
        bus_read(12'h008, 32'hDEAD_BEEF, 1'b0, "R1 t2 readback");
        bus_read(12'h00C, 32'h0BAD_F00D, 1'b0, "R1 t3 readback");
        bus_read(12'h010, 32'h8000_1000, 1'b0, "R1 ubase readback");
        bus_read(12'h014, 32'h8004_0000, 1'b0, "R1 lbase readback");
        // R5: current-base mirrors.
        bus_read(12'h02C, 32'h8000_1000, 1'b0, "R5 upper current");
        bus_read(12'h030, 32'h8004_0000, 1'b0, "R5 lower current");

        // R6: largest geometry.
        bus_write(12'h000, 32'h0000_00FF, 4'h0, 1'b0, "R6 t0 max");
        check(panel_width === 11'd1024, "R6 width max", 32'(panel_width), 32'd1024);
        bus_write(12'h004, 32'h0000_07FF, 4'h0, 1'b0, "R6 t1 max");
        check(panel_height === 11'd1024, "R6 height max", 32'(panel_height), 32'd1024);

        // R2/R7: strap 0, control at 0x1C, mask at 0x18.
        bus_write(12'h01C, 32'h0000_0F0B, 4'h0, 1'b0, "R2 ctrl v0");
        check(active === 1'b1, "R7 active both bits", 32'(active), 32'd1);
        check(bpp_code === 3'd5, "R7 bpp", 32'(bpp_code), 32'd5);
        check({bgr_order, be_bytes, be_pixels} === 3'b111, "R7 order bits",
              32'({bgr_order, be_bytes, be_pixels}), 32'h7);
        bus_write(12'h018, 32'h0000_0005, 4'h0, 1'b0, "R2 mask v0");
        check(active === 1'b1, "R2 mask write leaves ctrl", 32'(active), 32'd1);
        bus_read(12'h018, 32'h0000_0005, 1'b0, "R2 mask readback v0");
        bus_read(12'h01C, 32'h0000_0F0B, 1'b0, "R2 ctrl readback v0");
        bus_write(12'h01C, 32'h0000_0001, 4'h0, 1'b0, "R7 enable only");
        check(active === 1'b0, "R7 enable without power", 32'(active), 32'd0);
        bus_write(12'h01C, 32'h0000_0800, 4'h0, 1'b0, "R7 power only");
        check(active === 1'b0, "R7 power without enable", 32'(active), 32'd0);

        // R2: strap 1 swaps the two slots.
        ver_sel = 2'd1;
        bus_read(12'h018, 32'h0000_0800, 1'b0, "R2 ctrl seen at 0x18 v1");
        bus_read(12'h01C, 32'h0000_0005, 1'b0, "R2 mask seen at 0x1C v1");
        bus_write(12'h018, 32'h0000_0801, 4'h0, 1'b0, "R2 ctrl via 0x18 v1");
        check(active === 1'b1, "R2 swapped ctrl write", 32'(active), 32'd1);
        bus_write(12'h01C, 32'h0000_0003, 4'h0, 1'b0, "R2 mask via 0x1C v1");
        check(active === 1'b1, "R2 swapped mask leaves ctrl", 32'(active), 32'd1);
        bus_read(12'h01C, 32'h0000_0003, 1'b0, "R2 mask readback v1");

        // R3: events, raw and masked status, irq (mask = 0011).
        bus_write(12'h014, 32'h8004_0000, 4'b0100, 1'b0, "R3 event bit2");
        check(irq === 1'b0, "R3 masked-off event no irq", 32'(irq), 32'd0);
        bus_read(12'h020, 32'h0000_0004, 1'b0, "R3 raw status");
        bus_read(12'h024, 32'h0000_0000, 1'b0, "R3 masked status");
        bus_write(12'h014, 32'h8004_0000, 4'b0011, 1'b0, "R3 event bits1:0");
        check(irq === 1'b1, "R3 irq on unmasked event", 32'(irq), 32'd1);
        bus_read(12'h020, 32'h0000_0007, 1'b0, "R3 raw sticky");
        bus_read(12'h024, 32'h0000_0003, 1'b0, "R3 masked status 2");

        // R4: clear bits 1:0 while bit 0 gets a new event.
        bus_write(12'h028, 32'h0000_0003, 4'b0001, 1'b0, "R4 clear with event");
        bus_read(12'h020, 32'h0000_0005, 1'b0, "R4 event beats clear");
        bus_write(12'h028, 32'hFFFF_FFFF, 4'b0000, 1'b0, "R4 clear all");
        check(irq === 1'b0, "R4 irq after clear", 32'(irq), 32'd0);
        bus_read(12'h020, 32'h0000_0000, 1'b0, "R4 raw after clear");

        // R8: identification bytes for both ID sets.
        for (int k = 0; k < 8; k++)
            bus_read(12'hFE0 + 12'(k * 4), 32'(id_old[k]), 1'b0, "R8 id v1");
        ver_sel = 2'd2;
        for (int k = 0; k < 8; k++)
            bus_read(12'hFE0 + 12'(k * 4),
                     (k == 0) ? 32'h11 : (k == 2) ? 32'h24 : 32'(id_old[k]), 1'b0, "R8 id v2");
        bus_read(12'h018, 32'h0000_0801, 1'b0, "R2 ctrl at 0x18 v2");
        ver_sel = 2'd0;
        for (int k = 0; k < 8; k++)
            bus_read(12'hFE0 + 12'(k * 4), 32'(id_old[k]), 1'b0, "R8 id v0");

        // R9: palette window ends and middle.
        bus_write(12'h200, 32'hA1A1_0001, 4'h0, 1'b0, "R9 pal first");
        check(pmem[0] === 32'hA1A1_0001, "R9 pal idx 0", pmem[0], 32'hA1A1_0001);
        bus_write(12'h3FC, 32'hB2B2_007F, 4'h0, 1'b0, "R9 pal last");
        check(pmem[127] === 32'hB2B2_007F, "R9 pal idx 127", pmem[127], 32'hB2B2_007F);
        bus_write(12'h2A8, 32'hC3C3_002A, 4'h0, 1'b0, "R9 pal mid");
        check(pmem[42] === 32'hC3C3_002A, "R9 pal idx 42", pmem[42], 32'hC3C3_002A);
        bus_read(12'h3FC, 32'hB2B2_007F, 1'b0, "R9 pal read last");
        bus_read(12'h200, 32'hA1A1_0001, 1'b0, "R9 pal read first");
        bus_read(12'h2A8, 32'hC3C3_002A, 1'b0, "R9 pal read mid");

        // R10: unmapped reads and writes.
        bus_read(12'h034, 32'h0, 1'b1, "R10 read gap 0x34");
        bus_read(12'h028, 32'h0, 1'b1, "R10 read clear reg");
        bus_read(12'h400, 32'h0, 1'b1, "R10 read 0x400");
        bus_read(12'h1FC, 32'h0, 1'b1, "R10 read 0x1FC");
        bus_write(12'h01C, 32'h0000_0801, 4'b0010, 1'b0, "R10 setup ctrl v0");
        bus_write(12'h020, 32'hFFFF_FFFF, 4'h0, 1'b1, "R10 write raw status");
        bus_read(12'h020, 32'h0000_0002, 1'b0, "R10 raw unchanged");
        bus_write(12'h02C, 32'h1111_1111, 4'h0, 1'b1, "R10 write current base");
        bus_read(12'h010, 32'h8000_1000, 1'b0, "R10 ubase unchanged");
        bus_write(12'hFE0, 32'h0000_0055, 4'h0, 1'b1, "R10 write id");
        bus_read(12'hFE0, 32'h0000_0010, 1'b0, "R10 id unchanged");
        bus_write(12'h800, 32'h0000_0000, 4'h0, 1'b1, "R10 write far gap");
        check(active === 1'b1, "R10 ctrl unchanged", 32'(active), 32'd1);
        check(upper_base === 32'h8000_1000, "R10 base out unchanged", upper_base, 32'h8000_1000);

        // R11: change pulse lasts one cycle.
        @(negedge clk);
        check(cfg_changed === 1'b0, "R11 pulse ends", 32'(cfg_changed), 32'd0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R12 all responses seen", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule